// File: doc/BRIEF.md
# Convert-Start Framed Serial Result Port

This block is the read-out side of a small successive-approximation converter. The convert-start line doubles as a chip-select. Its rising edge resets the bit counter and arms the port. The following rising edges of the serial clock then shift the latched 8-bit result onto a single data line, most significant bit first. When the eighth serial clock falls, the line is released, and the port ignores any further serial clocks until convert-start rises again. This lets several converters share one serial bus, each framed by its own convert-start line.

The conversion sequencer hands over each finished result as a parallel word with a one-cycle load strobe. A read that starts before the load delivers the earlier result. A read that starts after it delivers the new one. If a load arrives while a read is in progress, the new word is parked and takes effect only once that read has finished. A read-in-progress flag lets the sequencer see when this is happening. The serial clock may run freely or only during reads. Both external lines are brought into the system clock domain through two-flop synchronisers, and all edges are taken from the synchronised values. The port does not depend on the converter core being powered, so reads also work while the core is down.

Top module: `conv_read_port`

## Requirements
- R1: After reset the data-enable output and the read-in-progress flag are 0, and the held result is 0.
- R2: Until convert-start has risen at least once since reset, serial clock pulses leave the data-enable output at 0 and the data output at 0.
- R3: The data-enable output rises on the first rising serial-clock edge after a convert-start rise, and not before it. At that moment the data output presents bit 7 of the held result.
- R4: Each of the next seven rising serial-clock edges presents the next lower bit (bit 6 down to bit 0), so exactly 8 bits go out, most significant first.
- R5: The data-enable output returns to 0, and the data output to 0, on the falling edge of the eighth serial clock.
- R6: After 8 bits have gone out, further serial clocks leave the data-enable output at 0 until the next convert-start rise.
- R7: A result loaded with the load strobe while no read is in progress is delivered by the next read.
- R8: A result loaded while a read is in progress does not change the bits of that read. It is delivered by the following read.
- R9: With a free-running serial clock that is already high when convert-start rises, the first bit appears only on the next rising serial-clock edge.
- R10: The read-in-progress flag is 1 from the first rising serial-clock edge of a read until the falling edge of its eighth clock, and 0 otherwise.
- R11: A convert-start rise in the middle of a read abandons that read. The data line is released, and the next rising serial-clock edge restarts at bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from the host, asynchronous |
| conv_i | input | 1 | Convert-start line; its rising edge arms the port, asynchronous |
| res_i | input | 8 | Parallel conversion result from the sequencer |
| res_load_i | input | 1 | One-cycle strobe that loads res_i |
| sdo_o | output | 1 | Serial data; 0 while not driven |
| sdo_oe_o | output | 1 | Data line drive enable; 0 means high impedance |
| busy_o | output | 1 | Read in progress |

## Verification
The bench arms the port while the serial clock is already high. A design that treated that level as an edge would emit bit 7 one clock early and drop bit 0. After a full read it keeps clocking, which catches a counter that wraps and starts driving the line again. It loads a new result in the middle of a read, which exposes a holding register that is overwritten at once and so corrupts the lower bits. It also re-arms in the middle of a read, where a counter that is not cleared would resume at the wrong bit or fail to release the line.

// File: rtl/conv_read_pkg.sv
package conv_read_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_SHIFT = 2'd2,
    ST_DONE  = 2'd3
  } port_state_e;
endpackage

// File: rtl/crp_sync.sv
module crp_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [STAGES-1:0][N-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= d_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[g] <= '0;
      else         stg_q[g] <= stg_q[g-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/crp_edge.sv
module crp_edge #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= d_i;
  end

  assign rise_o = d_i & ~prev_q;
  assign fall_o = ~d_i & prev_q;
endmodule

// File: rtl/crp_hold.sv
module crp_hold #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         busy_i,
  output logic [W-1:0] hold_o
);
  logic [W-1:0] hold_q, park_q;
  logic         park_vld_q;

  // loads during a read are parked until the read ends
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q     <= '0;
      park_q     <= '0;
      park_vld_q <= 1'b0;
    end else if (load_i && busy_i) begin
      park_q     <= data_i;
      park_vld_q <= 1'b1;
    end else if (load_i) begin
      hold_q     <= data_i;
      park_vld_q <= 1'b0;
    end else if (park_vld_q && !busy_i) begin
      hold_q     <= park_q;
      park_vld_q <= 1'b0;
    end
  end

  assign hold_o = hold_q;
endmodule

// File: rtl/crp_shift.sv
module crp_shift
  import conv_read_pkg::*;
#(
  parameter int W  = 8,
  parameter int CW = $clog2(W + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          arm_i,
  input  logic          sclk_rise_i,
  input  logic          sclk_fall_i,
  input  logic [W-1:0]  hold_i,
  output logic          sdo_o,
  output logic          oe_o,
  output logic          busy_o,
  output port_state_e   state_o,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] LAST = CW'(W);

  port_state_e   state_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  sh_q;
  logic          oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      oe_q    <= 1'b0;
    end else if (arm_i) begin
      state_q <= ST_ARMED;
      cnt_q   <= '0;
      oe_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_ARMED: if (sclk_rise_i) begin
          sh_q    <= hold_i;
          cnt_q   <= CW'(1);
          oe_q    <= 1'b1;
          state_q <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (sclk_rise_i && cnt_q != LAST) begin
            sh_q  <= {sh_q[W-2:0], 1'b0};
            cnt_q <= cnt_q + CW'(1);
          end else if (sclk_fall_i && cnt_q == LAST) begin
            oe_q    <= 1'b0;
            state_q <= ST_DONE;
          end
        end
        default: ;
      endcase
    end
  end

  assign sdo_o   = oe_q & sh_q[W-1];
  assign oe_o    = oe_q;
  assign busy_o  = (state_q == ST_SHIFT);
  assign state_o = state_q;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/conv_read_port.sv
module conv_read_port
  import conv_read_pkg::*;
#(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sclk_i,
  input  logic         conv_i,
  input  logic [W-1:0] res_i,
  input  logic         res_load_i,
  output logic         sdo_o,
  output logic         sdo_oe_o,
  output logic         busy_o
);
  localparam int CW = $clog2(W + 1);

  logic [1:0]    raw, syn, rise, fall;
  logic [W-1:0]  hold_q;
  port_state_e   state_q;
  logic [CW-1:0] cnt_q;

  assign raw = {conv_i, sclk_i};

  crp_sync #(.N(2), .STAGES(STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(raw), .q_o(syn)
  );

  crp_edge #(.N(2)) u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(syn), .rise_o(rise), .fall_o(fall)
  );

  crp_hold #(.W(W)) u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(res_load_i), .data_i(res_i),
    .busy_i(busy_o), .hold_o(hold_q)
  );

  crp_shift #(.W(W), .CW(CW)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .arm_i(rise[1]),
    .sclk_rise_i(rise[0]), .sclk_fall_i(fall[0]), .hold_i(hold_q),
    .sdo_o(sdo_o), .oe_o(sdo_oe_o), .busy_o(busy_o),
    .state_o(state_q), .cnt_o(cnt_q)
  );
endmodule

// File: rtl/conv_read_port_chk.sv
module conv_read_port_chk
  import conv_read_pkg::*;
#(
  parameter int W  = 8,
  parameter int CW = $clog2(W + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sdo_o,
  input logic          sdo_oe_o,
  input logic          busy_o,
  input logic [W-1:0]  hold_q,
  input port_state_e   state_q,
  input logic [CW-1:0] cnt_q
);
  // R3
  oe_rise_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sdo_oe_o) |-> busy_o && cnt_q == CW'(1));

  // R4
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (cnt_q >= CW'(1) && cnt_q <= CW'(W)));

  // R5
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> !sdo_oe_o && !sdo_o);

  // R6
  done_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DONE) |=> !sdo_oe_o);

  // R8
  hold_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(hold_q));

  // R10
  busy_drives_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> sdo_oe_o);
endmodule

bind conv_read_port conv_read_port_chk #(.W(W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o),
  .busy_o(busy_o), .hold_q(hold_q), .state_q(state_q), .cnt_q(cnt_q)
);

// File: tb/conv_read_port_bench.sv
module conv_read_port_bench;
  localparam int W = 8;

  typedef struct {
    logic  sdo;
    logic  oe;
    string tag;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, conv = 1'b0, load = 1'b0;
  logic [W-1:0] res = '0;
  logic sdo, oe, busy;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  exp_t exp_q[$];
  event smp_ev;

  always #10 clk = ~clk;

  conv_read_port #(.W(W)) u_conv_read_port (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .conv_i(conv),
    .res_i(res), .res_load_i(load), .sdo_o(sdo), .sdo_oe_o(oe), .busy_o(busy)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops expected items and compares live outputs
  always @(smp_ev) begin
    exp_t e;
    if (exp_q.size() == 0) begin
      n_bad++;
      $display("FAIL scoreboard: actual empty queue expected item");
    end else begin
      e = exp_q.pop_front();
      check({e.tag, " sdo"}, {7'd0, sdo}, {7'd0, e.sdo});
      check({e.tag, " oe"},  {7'd0, oe},  {7'd0, e.oe});
    end
  end

  task automatic push_smp(input logic s, input logic o, input string tag);
    exp_t e;
    e.sdo = s; e.oe = o; e.tag = tag;
    exp_q.push_back(e);
    -> smp_ev;
    #1;
  endtask

  task automatic load_res(input logic [W-1:0] v);
    res = v; load = 1'b1;
    cyc(1);
    load = 1'b0;
    cyc(1);
  endtask

  task automatic arm();
    conv = 1'b0; cyc(4);
    conv = 1'b1; cyc(6);
  endtask

  // clocks out one serial cycle pair; expects bit b driven after the rise
  task automatic sclk_cycle(input logic b, input logic drv, input logic last, input string tag);
    sclk = 1'b1; cyc(6);
    push_smp(b & drv, drv, tag);
    cyc(2);
    sclk = 1'b0; cyc(6);
    push_smp(last ? 1'b0 : (b & drv), last ? 1'b0 : drv, tag);
    cyc(2);
  endtask

  // full read; load_at >= 0 loads nv after that many bits (R8)
  task automatic read_byte(input logic [W-1:0] v, input string tag,
                           input int load_at = -1, input logic [W-1:0] nv = '0);
    for (int i = 0; i < W; i++) begin
      if (i == load_at) load_res(nv);
      sclk_cycle(v[W-1-i], 1'b1, i == W-1, tag);
      if (i == 0) check({tag, " R10 busy after first rise"}, {7'd0, busy}, 8'd1);
    end
    check({tag, " R10 busy after eighth fall"}, {7'd0, busy}, 8'd0);
  endtask

  initial begin
    cyc(3);
    // R1
    check("R1 oe", {7'd0, oe}, 8'd0);
    check("R1 busy", {7'd0, busy}, 8'd0);
    rst_n = 1'b1;
    cyc(4);
    check("R1 sdo", {7'd0, sdo}, 8'd0);

    // R2: clocks with no arm
    load_res(8'hFF);
    for (int i = 0; i < 3; i++) sclk_cycle(1'b0, 1'b0, 1'b0, "R2 unarmed");

    // R3 R4 R5 R7
    load_res(8'hA5);
    arm();
    check("R3 not driven before first rise", {7'd0, oe}, 8'd0);
    read_byte(8'hA5, "R4 R7 read A5");

    // R6: extra clocks ignored
    for (int i = 0; i < 4; i++) sclk_cycle(1'b0, 1'b0, 1'b0, "R6 after eight");
    check("R6 busy stays low", {7'd0, busy}, 8'd0);

    // R7: a second pattern
    load_res(8'h3C);
    arm();
    read_byte(8'h3C, "R7 read 3C");

    // R8: load during read is deferred
    arm();
    read_byte(8'h3C, "R8 old value kept", 3, 8'hC3);
    arm();
    read_byte(8'hC3, "R8 parked value next");

    // R9: free-running clock high when convert-start rises
    load_res(8'h81);
    sclk = 1'b1; cyc(8);
    arm();
    check("R9 no drive on level", {7'd0, oe}, 8'd0);
    sclk = 1'b0; cyc(8);
    check("R9 still idle", {7'd0, oe}, 8'd0);
    read_byte(8'h81, "R9 read 81");

    // R11: re-arm mid read
    load_res(8'h6E);
    arm();
    for (int i = 0; i < 3; i++) sclk_cycle(8'h6E >> (W-1-i), 1'b1, 1'b0, "R11 partial");
    arm();
    check("R11 released on re-arm", {7'd0, oe}, 8'd0);
    read_byte(8'h6E, "R11 restart");

    cyc(4);
    check("R3 scoreboard drained", 8'(exp_q.size()), 8'd0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule